// File: doc/BRIEF.md
# Pulse Period and Width Measurement Timer

This block is a single 16-bit timer channel with four operating modes. It can run as an interval timer that counts down on count-source ticks, or as an event counter that counts down on edges of an external input. It can also measure pulses, either the period between edges of one polarity or the successive high and low widths of the input. A small register interface holds the mode, the counter and reload value, and a start bit. A second read-only register holds the measured result.

In the two measurement modes the counter counts up on each tick. On every effective edge its value moves into the capture register and the counter restarts from zero. Counter wrap-around sets a sticky overflow status bit that software uses to tell an overflow interrupt from an edge interrupt. That bit can only be cleared by a mode write while the channel is running. The interrupt request is a single-cycle pulse that an external interrupt controller collects.

Top module: `pulse_meas_timer`

## Requirements
- R1: After reset the channel is stopped (start bit at address 2, bit 0, reads 0; mode register at address 0 reads 0; irq is low). The counter does not change while stopped, except when software writes it.
- R2: Timer mode (mode code 0 in address 0 bits [1:0]): while running, each tick decrements the counter. A tick that finds the counter at 0 reloads it from the reload value and raises irq. Reload value R therefore gives one irq every R+1 ticks.
- R3: A read of the counter (address 1) in a cycle in which a reload takes place returns all ones (16'hFFFF).
- R4: A counter write (address 1) while stopped sets both the counter and the reload value, and a later read returns the written value. The same write while running changes only the reload value.
- R5: Event mode (code 1): the counter decrements and reloads as in R2, but on effective input edges instead of ticks, and ticks have no effect. Bit 2 of the mode register picks the edge: 0 for rising, 1 for falling.
- R6: Measurement modes (codes 2 and 3): a tick that finds the counter at all ones wraps it to 0, sets the overflow bit (address 0, bit 7) and raises irq.
- R7: The overflow bit is cleared only by a mode-register write with bit 7 at 0 while running, and the clear takes effect at the next tick. A mode write while stopped leaves it set. A mode write while running changes no mode or polarity bit.
- R8: The first effective edge after the start bit goes from 0 to 1 loads the capture register (address 3) but raises no irq.
- R9: Period mode (code 2): only edges of the bit-2 polarity are effective. Each one copies the counter into the capture register and restarts the counter at 0. With a tick every cycle, the capture equals the edge spacing in cycles minus 1. The input is synchronized by two flops and an edge acts at the third rising clock edge after the input changes.
- R10: Width mode (code 3): both edge polarities are effective. Captures therefore alternate between the high width and the low width, each measured as in R9.
- R11: irq is a one-cycle pulse in the cycle after its cause. An effective edge and an overflow in the same cycle produce a single pulse, set the overflow bit, and capture 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address for write and read (0 mode, 1 counter, 2 start, 3 capture) |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for busAddr |
| tick | input | 1 | Count-source tick, one cycle per count |
| pulseIn | input | 1 | Asynchronous measurement or event input |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The bench sweeps reload values in timer mode and a grid of high and low widths in both measurement modes. It predicts interrupt counts and captured values arithmetically. An off-by-one in the reload path shows up as a wrong interrupt rate, and a design that failed to restart the counter on capture would report growing widths. The first-edge rule is checked by interrupt counts: a design that interrupts on it reports one pulse too many. The bench also times an edge to land on the exact overflow cycle, where a wrong design would emit two pulses, lose the overflow bit or capture zero. The overflow-clear rules are probed with writes while stopped, writes with no tick yet, and writes that try to change the mode while running.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER  = 2'd0,
    MODE_EVENT  = 2'd1,
    MODE_PERIOD = 2'd2,
    MODE_WIDTH  = 2'd3
  } opMode_e;

  localparam logic [1:0] ADDR_MODE    = 2'd0;
  localparam logic [1:0] ADDR_COUNT   = 2'd1;
  localparam logic [1:0] ADDR_START   = 2'd2;
  localparam logic [1:0] ADDR_CAPTURE = 2'd3;

  localparam int OVF_BIT = 7;
  localparam int POL_BIT = 2;

  typedef struct packed {
    logic loadCnt;     // software write of counter while stopped
    logic loadReload;  // software write of reload value
    logic capEdge;     // measurement capture and restart
    logic doReload;    // down-count reached zero: reload
    logic decr;        // down-count step
    logic upTick;      // measurement up-count step
  } strobes_t;
endpackage

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
  import pmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  input  logic             tick,
  input  logic             pulseIn,
  input  logic             cntZero,
  input  logic             cntMax,
  output strobes_t         str,
  output opMode_e          modeQ,
  output logic             polQ,
  output logic             ovfQ,
  output logic             startQ,
  output logic             firstPend,
  output logic             irq
);
  logic [SYNC_STAGES:0] syncQ;
  logic lvl, prevLvl, riseE, fallE, polEdge, effEdge, isMeas;
  logic trigDown, ovfEvt, modeWr, modeWrRun, startWr, irqNext, clrPend;

  // Synchronizer chain plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], pulseIn};
  end

  assign lvl     = syncQ[SYNC_STAGES-1];
  assign prevLvl = syncQ[SYNC_STAGES];
  assign riseE   = lvl & ~prevLvl;
  assign fallE   = ~lvl & prevLvl;
  assign polEdge = polQ ? fallE : riseE;
  assign effEdge = (modeQ == MODE_WIDTH) ? (riseE | fallE) : polEdge;
  assign isMeas  = modeQ[1];

  assign trigDown = (modeQ == MODE_TIMER) ? tick : effEdge;

  always_comb begin
    str            = '0;
    str.loadReload = busWr && (busAddr == ADDR_COUNT);
    str.loadCnt    = str.loadReload && !startQ;
    str.capEdge    = startQ && isMeas && effEdge;
    str.upTick     = startQ && isMeas && tick && !effEdge;
    str.doReload   = startQ && !isMeas && trigDown && cntZero;
    str.decr       = startQ && !isMeas && trigDown && !cntZero;
  end

  assign ovfEvt    = startQ && isMeas && tick && cntMax;
  assign modeWr    = busWr && (busAddr == ADDR_MODE);
  assign modeWrRun = modeWr && startQ;
  assign startWr   = busWr && (busAddr == ADDR_START);

  // Mode, polarity and start registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_TIMER;
      polQ   <= 1'b0;
      startQ <= 1'b0;
    end else begin
      if (modeWr && !startQ) begin
        modeQ <= opMode_e'(busWrData[1:0]);
        polQ  <= busWrData[POL_BIT];
      end
      if (startWr) startQ <= busWrData[0];
    end
  end

  // First-edge suppression after a 0->1 start transition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) firstPend <= 1'b0;
    else if (startWr && busWrData[0] && !startQ) firstPend <= 1'b1;
    else if (str.capEdge) firstPend <= 1'b0;
  end

  // Sticky overflow flag with deferred clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfQ    <= 1'b0;
      clrPend <= 1'b0;
    end else begin
      if (ovfEvt) ovfQ <= 1'b1;
      else if (startQ && tick && clrPend) ovfQ <= 1'b0;

      if (modeWrRun) clrPend <= !busWrData[OVF_BIT];
      else if (startQ && tick) clrPend <= 1'b0;
    end
  end

  assign irqNext = str.doReload || (str.capEdge && !firstPend) || ovfEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= irqNext;
  end
endmodule

// File: rtl/pmt_datapath.sv
module pmt_datapath
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         str,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] capQ,
  output logic             cntZero,
  output logic             cntMax
);
  logic [CNT_W-1:0] reloadQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reloadQ <= '0;
    else if (str.loadReload) reloadQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      capQ <= '0;
    end else begin
      if (str.loadCnt) begin
        cntQ <= wrData;
      end else if (str.capEdge) begin
        capQ <= cntQ;
        cntQ <= '0;
      end else if (str.doReload) begin
        cntQ <= reloadQ;
      end else if (str.decr) begin
        cntQ <= cntQ - 1'b1;
      end else if (str.upTick) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign cntZero = (cntQ == '0);
  assign cntMax  = &cntQ;
endmodule

// File: rtl/pulse_meas_timer.sv
module pulse_meas_timer
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busAddr,
  input  logic [CNT_W-1:0] busWrData,
  output logic [CNT_W-1:0] busRdData,
  input  logic             tick,
  input  logic             pulseIn,
  output logic             irq
);
  strobes_t         str;
  opMode_e          modeQ;
  logic             polQ, ovfQ, startQ, firstPend, cntZero, cntMax;
  logic [CNT_W-1:0] cntQ, capQ;

  pmt_ctrl #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .tick(tick), .pulseIn(pulseIn),
    .cntZero(cntZero), .cntMax(cntMax), .str(str), .modeQ(modeQ),
    .polQ(polQ), .ovfQ(ovfQ), .startQ(startQ), .firstPend(firstPend),
    .irq(irq)
  );

  pmt_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .str(str), .wrData(busWrData),
    .cntQ(cntQ), .capQ(capQ), .cntZero(cntZero), .cntMax(cntMax)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_MODE: begin
        busRdData[1:0]     = modeQ;
        busRdData[POL_BIT] = polQ;
        busRdData[OVF_BIT] = ovfQ;
      end
      ADDR_COUNT:   busRdData = str.doReload ? '1 : cntQ;
      ADDR_START:   busRdData[0] = startQ;
      default:      busRdData = capQ;
    endcase
  end
endmodule

// File: rtl/pulse_meas_timer_chk.sv
module pulse_meas_timer_chk
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startQ,
  input logic             ovfQ,
  input logic             firstPend,
  input logic             tick,
  input logic             irq,
  input logic [1:0]       busAddr,
  input logic [CNT_W-1:0] busRdData,
  input logic [CNT_W-1:0] cntQ,
  input strobes_t         str
);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!startQ && !str.loadCnt) |=> $stable(cntQ));

  p_reload_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (str.doReload && busAddr == ADDR_COUNT) |-> (&busRdData));

  p_ovf_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> irq);

  p_ovf_set_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> $past(startQ));

  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfQ) |-> $past(startQ && tick));

  p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (str.capEdge && firstPend && !(str.upTick && (&cntQ)) && !(tick && (&cntQ)))
      |=> !irq);

  p_cap_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    str.capEdge |=> (cntQ == '0));

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({str.capEdge, str.doReload, str.decr, str.upTick}));
endmodule

bind pulse_meas_timer pulse_meas_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .startQ(startQ), .ovfQ(ovfQ),
  .firstPend(firstPend), .tick(tick), .irq(irq), .busAddr(busAddr),
  .busRdData(busRdData), .cntQ(cntQ), .str(str)
);

// File: tb/pulse_meas_timer_tb.sv
module pulse_meas_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'd0;
  logic [15:0] busRdData;
  logic        tick = 1'b0;
  logic        pulseIn = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int irqCnt = 0;

  always #5 clk = ~clk;

  pulse_meas_timer dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .tick(tick),
    .pulseIn(pulseIn), .irq(irq)
  );

  always @(posedge clk) if (irq) irqCnt <= irqCnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdData);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Measurement sweep: npulse pulses of h high and l low, tick every cycle
  task automatic measRun(input int mode, input int h, input int l);
    int base, v;
    pulseIn = 1'b0;
    tick = 1'b0;
    wr(2'd2, 16'd0);
    wr(2'd0, 16'(mode));
    cyc(4);
    wr(2'd2, 16'd1);
    tick = 1'b1;
    base = irqCnt;
    for (int p = 0; p < 3; p++) begin
      pulseIn = 1'b1;
      cyc(h);
      if (mode == 3 && p > 0) begin
        rd(2'd3, v);
        chk("R10 low width", v, l - 1);
      end
      pulseIn = 1'b0;
      cyc(l);
      if (mode == 2 && p > 0) begin
        rd(2'd3, v);
        chk("R9 period", v, h + l - 1);
      end
      if (mode == 3) begin
        rd(2'd3, v);
        chk("R10 high width", v, h - 1);
      end
    end
    cyc(3);
    tick = 1'b0;
    wr(2'd2, 16'd0);
    cyc(2);
    chk("R8 irq count excludes first edge", irqCnt - base, (mode == 2) ? 2 : 5);
  endtask

  initial begin
    int v, base;
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    rd(2'd2, v); chk("R1 start after reset", v, 0);
    rd(2'd0, v); chk("R1 mode after reset", v, 0);
    chk("R1 irq after reset", int'(irq), 0);
    tick = 1'b1;
    cyc(5);
    rd(2'd1, v); chk("R1 counter idle while stopped", v, 0);
    chk("R1 no irq while stopped", irqCnt, 0);
    tick = 1'b0;

    // R4 counter write while stopped / running
    wr(2'd1, 16'h1234);
    rd(2'd1, v); chk("R4 readback while stopped", v, 16'h1234);
    wr(2'd2, 16'd1);
    wr(2'd1, 16'd5);
    rd(2'd1, v); chk("R4 running write leaves counter", v, 16'h1234);
    wr(2'd2, 16'd0);

    // R2 timer sweep over reload values
    for (int r = 0; r < 6; r++) begin
      wr(2'd1, 16'(r));
      wr(2'd2, 16'd1);
      base = irqCnt;
      tick = 1'b1;
      if (r == 0) begin
        rd(2'd1, v); chk("R3 read during reload", v, 16'hFFFF);
      end
      cyc(20);
      tick = 1'b0;
      if (r == 0) begin
        rd(2'd1, v); chk("R3 plain read outside reload", v, 0);
      end
      cyc(3);
      wr(2'd2, 16'd0);
      chk("R2 irq rate", irqCnt - base, 20 / (r + 1));
    end

    // R5 event counter, rising then falling
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd0, pol ? 16'h0005 : 16'h0001);
      wr(2'd1, pol ? 16'd1 : 16'd2);
      cyc(4);
      wr(2'd2, 16'd1);
      tick = 1'b1;
      base = irqCnt;
      for (int p = 0; p < (pol ? 4 : 6); p++) begin
        pulseIn = 1'b1; cyc(3);
        pulseIn = 1'b0; cyc(3);
      end
      cyc(3);
      tick = 1'b0;
      wr(2'd2, 16'd0);
      chk(pol ? "R5 falling events irq" : "R5 rising events irq", irqCnt - base, 2);
      rd(2'd1, v); chk("R5 counter after events", v, pol ? 1 : 2);
    end

    // R9 / R10 / R8 measurement sweeps
    for (int h = 3; h < 8; h++)
      for (int l = 3; l < 8; l++) begin
        measRun(2, h, l);
        measRun(3, h, l);
      end

    // R6 / R7 overflow and clear
    wr(2'd0, 16'h0003);
    wr(2'd1, 16'hFFF0);
    wr(2'd2, 16'd1);
    base = irqCnt;
    tick = 1'b1; cyc(20); tick = 1'b0;
    cyc(2);
    rd(2'd0, v); chk("R6 overflow bit set", (v >> 7) & 1, 1);
    chk("R6 overflow irq", irqCnt - base, 1);
    rd(2'd1, v); chk("R6 counter wrapped", v, 4);
    wr(2'd0, 16'h0002);
    cyc(3);
    rd(2'd0, v); chk("R7 clear waits for tick", (v >> 7) & 1, 1);
    chk("R7 mode kept during running write", v & 7, 3);
    tick = 1'b1; cyc(1); tick = 1'b0;
    cyc(1);
    rd(2'd0, v); chk("R7 cleared at tick", (v >> 7) & 1, 0);
    wr(2'd2, 16'd0);
    wr(2'd1, 16'hFFFE);
    wr(2'd2, 16'd1);
    tick = 1'b1; cyc(3); tick = 1'b0;
    wr(2'd2, 16'd0);
    wr(2'd0, 16'h0003);
    cyc(2);
    rd(2'd0, v); chk("R7 stopped write keeps flag", (v >> 7) & 1, 1);
    wr(2'd2, 16'd1);
    wr(2'd0, 16'h0003);
    tick = 1'b1; cyc(1); tick = 1'b0;
    cyc(1);
    wr(2'd2, 16'd0);
    rd(2'd0, v); chk("R7 running write then tick clears", (v >> 7) & 1, 0);

    // R11 edge coincident with overflow
    pulseIn = 1'b0;
    wr(2'd1, 16'd0);
    cyc(4);
    wr(2'd2, 16'd1);
    tick = 1'b1;
    base = irqCnt;
    pulseIn = 1'b1;
    cyc(65536);
    pulseIn = 1'b0;
    cyc(4);
    tick = 1'b0;
    cyc(2);
    chk("R11 single pulse for edge plus overflow", irqCnt - base, 1);
    rd(2'd0, v); chk("R11 overflow bit with edge", (v >> 7) & 1, 1);
    rd(2'd3, v); chk("R11 capture at overflow edge", v, 16'hFFFF);
    wr(2'd2, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule